// File: doc/BRIEF.md
# Third-Order Sigma-Delta Frequency Step Modulator

This block turns a fine-resolution frequency control word into a stream of coarse oscillator settings. On every update tick it advances a third-order noise-shaping modulator built from three cascaded first-order accumulators. The block then issues a one-cycle write strobe that carries one of nine discrete frequency steps. The nine steps are numbered 0 to 8 around a centre setting. The fine part of the control word is carried by how often the modulator moves between neighbouring steps. The quantisation noise that results is pushed towards high frequencies, where the oscillator's downstream filtering removes it.

A slow control loop sends new control words whenever it likes, with a single-cycle valid. The block takes each word into a holding register straight away and never stalls the modulator. The update tick comes from a divider outside the block and typically runs at 1 MHz or 500 kHz. The loop filter that produces the control word and the oscillator that consumes the step are not part of this block.

Top module: `sdm3_freq_mod`

## Requirements
- R1: While reset is high, and in the first cycle after it, `step_idx` equals 4 (the centre step, offset zero) and `wr_strobe` is low. All accumulators and carry history are cleared.
- R2: Each cycle with `tick` high is followed, in the very next cycle, by exactly one cycle of `wr_strobe` high. `wr_strobe` is never high in a cycle that does not follow a tick.
- R3: `step_idx` changes only in a cycle that follows a tick. At all other times it holds its value.
- R4: `step_idx` never leaves 0..8, and the step offset it represents is `step_idx - 4`. When the modulator's raw offset is below -4 or above +4, the index is clamped to 0 or 8.
- R5: `ctrl_word` is a two's-complement value of INT_W+FRAC_W bits (defaults 4+16), read as `ctrl_word / 2^FRAC_W` steps. It is captured in every cycle where `ctrl_valid` is high, whatever the state of `tick`, and ticks keep producing strobes while words arrive.
- R6: A word captured with `ctrl_valid` in cycle t is first used by a tick in a cycle after t. A tick in cycle t itself still uses the previously held word.
- R7: At each tick, the raw offset is the integer part of the held word plus c1 + (c2 - c2') + (c3 - 2*c3' + c3''). Here c1, c2 and c3 are the carries of three FRAC_W-bit accumulators. The first accumulator adds the fraction of the word. Each later accumulator adds the new sum of the one before it. A prime marks the value at the previous tick, and a double prime the value two ticks back.
- R8: For a constant word in the range [-1, +1), the sum of step offsets over N ticks after reset differs from N times the word's value by at most 4 steps.
- R9: A word with a zero fraction, applied after reset, gives the constant index (integer part + 4) on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | INT_W+FRAC_W | Signed fixed-point frequency offset, in steps |
| ctrl_valid | input | 1 | Captures ctrl_word this cycle |
| tick | input | 1 | Modulator update request, one cycle wide |
| step_idx | output | 4 | Selected frequency step, 0..8 |
| wr_strobe | output | 1 | One-cycle register-write strobe carrying step_idx |

## Verification
Every result is due exactly one cycle after the tick that produced it. The accumulators and carry history advance on the tick edge, and `step_idx` and `wr_strobe` are registered on that same edge, so both are valid from the next cycle onward. A captured word is seen only from the edge after its valid. The bench's reference model therefore steps on each rising edge in the same order: it first computes the tick's result from the word held before that edge, and only then absorbs any new word. Outputs are compared with the model at every falling edge. The clamp, the zero-fraction case, a word arriving together with a tick, and the long-run averages are each checked separately at the cycle they are due.

// File: rtl/sdm3_pkg.sv
package sdm3_pkg;

    localparam int ORDER   = 3;
    localparam int LEVELS  = 9;
    localparam int CENTRE  = (LEVELS - 1) / 2;
    localparam int IDX_W   = $clog2(LEVELS);
    localparam int OFF_W   = 8;

    typedef logic [IDX_W-1:0]        step_idx_t;
    typedef logic signed [OFF_W-1:0] offset_t;

    // carries produced by the three stages at the current tick
    typedef struct packed {
        logic c1;
        logic c2;
        logic c3;
    } carry_vec_t;

    // carry history needed by the difference network
    typedef struct packed {
        logic c2_d;
        logic c3_d;
        logic c3_dd;
    } carry_hist_t;

    // shaped noise term: c1 + (1-z)c2 + (1-z)^2 c3
    function automatic offset_t noise_of(input carry_vec_t c, input carry_hist_t h);
        offset_t n;
        n = offset_t'(c.c1)
          + offset_t'(c.c2) - offset_t'(h.c2_d)
          + offset_t'(c.c3) - offset_t'(h.c3_d) - offset_t'(h.c3_d)
          + offset_t'(h.c3_dd);
        return n;
    endfunction

    // signed offset to step index, saturating at both ends
    function automatic step_idx_t offset_to_index(input offset_t off);
        step_idx_t idx;
        if (off < -offset_t'(CENTRE))
            idx = '0;
        else if (off > offset_t'(CENTRE))
            idx = step_idx_t'(LEVELS - 1);
        else
            idx = step_idx_t'(off + offset_t'(CENTRE));
        return idx;
    endfunction

endpackage

// File: rtl/sdm3_word_hold.sv
module sdm3_word_hold #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (valid)
            held <= word;
    end

    // R5: a valid word is always taken, never refused
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        valid |=> held == $past(word))
        else $error("word not captured");

    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(held))
        else $error("held word changed without valid");

endmodule

// File: rtl/sdm3_accum.sv
module sdm3_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    logic [W-1:0] acc;
    logic [W:0]   wide;

    always_comb begin
        wide    = {1'b0, acc} + {1'b0, din};
        sum_o   = wide[W-1:0];
        carry_o = wide[W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= sum_o;
    end

    // R3: no tick, no movement of the accumulator
    p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc))
        else $error("accumulator moved without tick");

    // R7: a carry is reported exactly when the modular sum wrapped
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        carry_o == (sum_o < din))
        else $error("carry does not match wrap");

endmodule

// File: rtl/sdm3_shaper.sv
module sdm3_shaper
    import sdm3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  offset_t    int_part,
    input  carry_vec_t carries,
    output step_idx_t  idx_next
);

    carry_hist_t hist;
    offset_t     noise;
    offset_t     total;

    always_comb begin
        noise    = noise_of(carries, hist);
        total    = int_part + noise;
        idx_next = offset_to_index(total);
    end

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (en)
            hist <= '{c2_d: carries.c2, c3_d: carries.c3, c3_dd: hist.c3_d};
    end

    // R7: third-order shaped noise stays within -3..+4 steps
    p_noise_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (noise >= -offset_t'(3)) && (noise <= offset_t'(4)))
        else $error("noise term out of bounds");

    // R4: the chosen index is always a legal step
    p_idx_legal_r4: assert property (@(posedge clk) disable iff (rst)
        idx_next <= step_idx_t'(LEVELS - 1))
        else $error("index beyond last step");

endmodule

// File: rtl/sdm3_freq_mod.sv
module sdm3_freq_mod
    import sdm3_pkg::*;
#(
    parameter int FRAC_W = 16,
    parameter int INT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [INT_W+FRAC_W-1:0] ctrl_word,
    input  logic                    ctrl_valid,
    input  logic                    tick,
    output logic [IDX_W-1:0]        step_idx,
    output logic                    wr_strobe
);

    localparam int WORD_W = INT_W + FRAC_W;

    logic [WORD_W-1:0] held;
    logic [FRAC_W-1:0] stage_in  [ORDER];
    logic [FRAC_W-1:0] stage_sum [ORDER];
    logic [ORDER-1:0]  stage_c;
    offset_t           int_part;
    carry_vec_t        carries;
    step_idx_t         idx_next;

    sdm3_word_hold #(.WORD_W(WORD_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .valid (ctrl_valid),
        .word  (ctrl_word),
        .held  (held)
    );

    assign int_part = OFF_W'($signed(held[WORD_W-1:FRAC_W]));

    for (genvar s = 0; s < ORDER; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign stage_in[s] = held[FRAC_W-1:0];
        end else begin : g_next
            assign stage_in[s] = stage_sum[s-1];
        end
        sdm3_accum #(.W(FRAC_W)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .en      (tick),
            .din     (stage_in[s]),
            .sum_o   (stage_sum[s]),
            .carry_o (stage_c[s])
        );
    end

    assign carries = '{c1: stage_c[0], c2: stage_c[1], c3: stage_c[2]};

    sdm3_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .en       (tick),
        .int_part (int_part),
        .carries  (carries),
        .idx_next (idx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step_idx  <= step_idx_t'(CENTRE);
            wr_strobe <= 1'b0;
        end else begin
            wr_strobe <= tick;
            if (tick)
                step_idx <= idx_next;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (step_idx == step_idx_t'(CENTRE)) && !wr_strobe)
        else $error("reset state wrong");

    p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> wr_strobe)
        else $error("missing write strobe");

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !wr_strobe)
        else $error("spurious write strobe");

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(step_idx))
        else $error("step changed without tick");

    p_range_r4: assert property (@(posedge clk) disable iff (rst)
        step_idx <= step_idx_t'(LEVELS - 1))
        else $error("step index out of range");

endmodule

// File: tb/tb_sdm3_freq_mod.sv
module tb_sdm3_freq_mod;

    localparam int FRAC_W = 16;
    localparam int INT_W  = 4;
    localparam int WW     = FRAC_W + INT_W;
    localparam int M      = 1 << FRAC_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WW-1:0] ctrl_word = '0;
    logic          ctrl_valid = 1'b0;
    logic          tick = 1'b0;
    logic [3:0]    step_idx;
    logic          wr_strobe;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    sdm3_freq_mod #(.FRAC_W(FRAC_W), .INT_W(INT_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_word  (ctrl_word),
        .ctrl_valid (ctrl_valid),
        .tick       (tick),
        .step_idx   (step_idx),
        .wr_strobe  (wr_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int      ph1, ph2, ph3;       // fractional phases, 0..M-1
    int      c2p, c3p, c3pp;
    logic [WW-1:0] m_word;
    int      exp_idx = 4;
    bit      exp_wr  = 0;
    bit      model_live = 0;
    int      t_ip, t_f, t_s, t_c1, t_c2, t_c3, t_y;

    always @(posedge clk) begin
        model_live = 1;
        if (rst) begin
            ph1 = 0; ph2 = 0; ph3 = 0; c2p = 0; c3p = 0; c3pp = 0;
            m_word = '0; exp_idx = 4; exp_wr = 0;
        end else begin
            exp_wr = tick;
            if (tick) begin
                t_ip = $signed(m_word[WW-1:FRAC_W]);
                t_f  = int'(m_word[FRAC_W-1:0]);
                t_s = ph1 + t_f;  t_c1 = (t_s >= M) ? 1 : 0; ph1 = t_s % M;
                t_s = ph2 + ph1;  t_c2 = (t_s >= M) ? 1 : 0; ph2 = t_s % M;
                t_s = ph3 + ph2;  t_c3 = (t_s >= M) ? 1 : 0; ph3 = t_s % M;
                t_y = t_ip + t_c1 + (t_c2 - c2p) + (t_c3 - 2 * c3p + c3pp);
                c3pp = c3p; c3p = t_c3; c2p = t_c2;
                if (t_y < -4) exp_idx = 0;
                else if (t_y > 4) exp_idx = 8;
                else exp_idx = t_y + 4;
            end
            if (ctrl_valid) m_word = ctrl_word;
        end
    end

    // per-clock comparison and tick-result bookkeeping
    longint acc_sum = 0;
    int     acc_n = 0;
    int     strobes = 0;
    int     hits8 = 0;

    always @(negedge clk) begin
        if (model_live) begin
            check(step_idx == 4'(exp_idx), "R7 step sequence", int'(step_idx), exp_idx);
            check(wr_strobe == exp_wr, "R2 strobe timing", int'(wr_strobe), int'(exp_wr));
            if (wr_strobe) begin
                acc_sum += longint'(int'(step_idx) - 4);
                acc_n++;
                strobes++;
                if (step_idx == 4'd8) hits8++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset();
        @(negedge clk); rst = 1'b1; ctrl_valid = 1'b0; tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input logic [WW-1:0] w);
        @(negedge clk); ctrl_word = w; ctrl_valid = 1'b1;
        @(negedge clk); ctrl_valid = 1'b0;
    endtask

    task automatic run(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic clear_stats();
        acc_sum = 0; acc_n = 0; strobes = 0; hits8 = 0;
    endtask

    task automatic avg_check(input int word_val, input string req);
        longint err;
        err = acc_sum * M - longint'(acc_n) * word_val;
        if (err < 0) err = -err;
        check(err <= 4 * longint'(M), req, int'(err / M), 4);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int snap;

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        check(step_idx == 4'd4, "R1 reset index", int'(step_idx), 4);
        check(wr_strobe == 1'b0, "R1 reset strobe", int'(wr_strobe), 0);
        rst = 1'b0;

        // R9: zero-fraction words give constant steps
        load(20'h20000);           // +2.0
        run(8, 1);
        check(step_idx == 4'd6, "R9 integer +2", int'(step_idx), 6);
        load(20'hC0000);           // -4.0
        run(4, 0);
        check(step_idx == 4'd0, "R9 integer -4", int'(step_idx), 0);

        // R3: no tick, no change
        snap = int'(step_idx);
        repeat (10) @(negedge clk);
        check(int'(step_idx) == snap, "R3 idle hold", int'(step_idx), snap);

        // R6: word arriving together with a tick is not used by that tick
        do_reset();
        @(negedge clk); ctrl_word = 20'h30000; ctrl_valid = 1'b1; tick = 1'b1;
        @(negedge clk); ctrl_valid = 1'b0; tick = 1'b0;
        check(step_idx == 4'd4, "R6 old word on same-cycle tick", int'(step_idx), 4);
        check(wr_strobe == 1'b1, "R6 strobe on same-cycle tick", int'(wr_strobe), 1);
        run(1, 0);
        check(step_idx == 4'd7, "R6 new word on next tick", int'(step_idx), 7);

        // R8: long-run average, positive fraction
        do_reset();
        load(20'd19661);           // ~ +0.3
        clear_stats();
        run(4096, 0);
        @(negedge clk);
        avg_check(19661, "R8 average +0.3");

        // R8: long-run average, negative word
        do_reset();
        load(20'((1 << 20) - 45875)); // ~ -0.7
        clear_stats();
        run(4096, 0);
        @(negedge clk);
        avg_check(-45875, "R8 average -0.7");

        // R4: clamp at the top step
        do_reset();
        load(20'h3C000);           // +3.75
        clear_stats();
        run(512, 0);
        @(negedge clk);
        check(hits8 > 0, "R4 clamp reaches step 8", hits8, 1);

        // R5: words arriving mid-period never stall the strobes
        do_reset();
        clear_stats();
        for (int k = 0; k < 64; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0; ctrl_valid = 1'b1;
            ctrl_word = 20'(k * 1733 + 1000);
            @(negedge clk); ctrl_valid = 1'b0;
        end
        repeat (2) @(negedge clk);
        check(strobes == 64, "R5 strobes per tick with busy control", strobes, 64);
        check(step_idx <= 4'd8, "R4 index in range", int'(step_idx), 8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule